// File: doc/BRIEF.md
# Synchronous Burst SRAM Control Front-End

This block is the clocked control path of a single-cycle-deselect pipelined burst SRAM. On every rising clock edge it samples two competing address strobes (one for a processor, one for a controller), three chip enables, an advance input, a write enable and a static burst-order strap. From these it keeps a registered base address and a two-bit burst counter, and it produces the word address of the current access, whether the device is selected, and whether the current access is a read.

A small behavioural memory array with a registered read port sits behind the control path, so reads and writes can be observed at the ports. Each access cycle issues its data phase at the following edge. Write data is taken at that edge, and read data is registered there and shown one clock after the address edge. An asynchronous active-low output enable gates the read data. This gate is additionally held off for the first read data word that follows a deselected state.

Top module: `sram_burst_front`

## Requirements
- R1: When an address load occurs at a clock edge, `word_addr` equals the `addr_in` value sampled at that edge from the following cycle on, and its two low bits become the burst start value.
- R2: If both strobes are low in the same cycle (with `en1_n` low), the processor strobe wins, and the access is a read whatever `we_n` is. A load from the controller strobe alone takes the write indication from `we_n` (low means write).
- R3: While `en1_n` is high, a low `proc_as_n` has no effect. With `ctrl_as_n` high, the address and the selection state are kept.
- R4: The device is selected when `en1_n`=0, `en2`=1 and `en3_n`=0, sampled only at a load edge. In any other cycle, changes on the enables leave `selected` unchanged.
- R5: With `order_sel`=0 and `adv_n` low while selected, the two low address bits step start, start+1, start+2, start+3 modulo 4.
- R6: With `order_sel`=1 and `adv_n` low while selected, the two low address bits are start XOR 0, 1, 2, 3 in that order, and then repeat.
- R7: With no load and `adv_n` high, `word_addr` and `selected` hold their values.
- R8: A selected read at an address edge gives `rdata_valid`=1 one clock later, with the stored word on `rdata` when the gate is open.
- R9: While deselected, no write reaches the memory and `rdata_valid` is 0 one clock after a deselected cycle.
- R10: `rdata` is 0 whenever `oe_gate` is 0. `oe_gate` is 1 only for valid read data with `oe_n` low, and it is 0 for the first read data word after a deselected state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| proc_as_n | input | 1 | Processor address strobe, active low |
| ctrl_as_n | input | 1 | Controller address strobe, active low |
| en1_n | input | 1 | Chip enable 1, active low; also masks the processor strobe |
| en2 | input | 1 | Chip enable 2, active high |
| en3_n | input | 1 | Chip enable 3, active low |
| adv_n | input | 1 | Burst advance, active low |
| we_n | input | 1 | Write enable, active low |
| order_sel | input | 1 | Burst-order strap: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr_in | input | AW | External word address |
| wdata | input | DW | Write data, taken at the data-phase edge |
| word_addr | output | AW | Current access word address |
| selected | output | 1 | Device selected state |
| rd_phase | output | 1 | Current access is a selected read |
| oe_gate | output | 1 | Read data output gate |
| rdata | output | DW | Gated read data |
| rdata_valid | output | 1 | Registered read data present |

## Verification
The bench runs a full linear write burst that wraps past the fourth word, then reads the data back in interleaved order and again in linear order. A counter that ignored the strap or did not wrap would return words in the wrong order. It drives both strobes together with write enable low, and a wrong priority would turn that access into a write. It pulses the processor strobe with the first enable high, and it toggles the enables without a strobe. A design that did not mask the strobe, or that decoded the enables on every cycle, would move the address or drop the selection. The bench also attempts writes while deselected and then reads that word back. It checks that the first read word after a deselect stays gated while the later words appear.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
   localparam int BURST_W = 2;
   typedef logic [BURST_W-1:0] burst_idx_t;

   // low address bits for a given start, step count and burst order
   function automatic burst_idx_t burst_word(input burst_idx_t start,
                                             input burst_idx_t step,
                                             input logic interleave);
      burst_word = interleave ? (start ^ step) : (start + step);
   endfunction
endpackage

// File: rtl/sbf_access_ctl.sv
module sbf_access_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic proc_as_n,
   input  logic ctrl_as_n,
   input  logic en1_n,
   input  logic en2,
   input  logic en3_n,
   input  logic we_n,
   output logic load,
   output logic proc_win,
   output logic selected,
   output logic is_wr
);
   logic enables_ok;

   assign proc_win   = !proc_as_n && !en1_n;
   assign load       = proc_win || !ctrl_as_n;
   assign enables_ok = !en1_n && en2 && !en3_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         selected <= 1'b0;
         is_wr    <= 1'b0;
      end else begin
         if (load) selected <= enables_ok;
         if (proc_win) is_wr <= 1'b0;
         else          is_wr <= !we_n;
      end
   end

   AST_PROC_READ: assert property (@(posedge clk) disable iff (!rst_n)
      proc_win |=> !is_wr); // R2
   AST_SEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(selected)); // R4
   AST_PROC_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (en1_n && ctrl_as_n) |=> $stable(selected)); // R3
endmodule

// File: rtl/sbf_burst_ctr.sv
module sbf_burst_ctr
   import sbf_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic       adv,
   input  logic       order_sel,
   input  burst_idx_t start_low,
   output burst_idx_t low
);
   burst_idx_t start_q;
   burst_idx_t step_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         step_q  <= '0;
      end else if (load) begin
         start_q <= start_low;
         step_q  <= '0;
      end else if (adv) begin
         step_q  <= step_q + 1'b1;
      end
   end

   assign low = burst_word(start_q, step_q, order_sel);

   AST_LIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load && !order_sel) |=> (low == $past(low) + 2'd1)); // R5
   AST_ILV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load && order_sel) |=> ((low ^ start_q) == (($past(low) ^ start_q) + 2'd1))); // R6
   AST_LOAD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (low == burst_word($past(start_low), 2'd0, order_sel))); // R1
endmodule

// File: rtl/sbf_mem.sv
module sbf_mem #(
   parameter int AW = 6,
   parameter int DW = 16,
   localparam int DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata_q,
   output logic          rd_valid
);
   logic [DW-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) store[addr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rdata_q <= store[addr];
      end
   end

   AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && rd_en)); // R9
endmodule

// File: rtl/sram_burst_front.sv
module sram_burst_front
   import sbf_pkg::*;
#(
   parameter int AW = 6,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          proc_as_n,
   input  logic          ctrl_as_n,
   input  logic          en1_n,
   input  logic          en2,
   input  logic          en3_n,
   input  logic          adv_n,
   input  logic          we_n,
   input  logic          order_sel,
   input  logic          oe_n,
   input  logic [AW-1:0] addr_in,
   input  logic [DW-1:0] wdata,
   output logic [AW-1:0] word_addr,
   output logic          selected,
   output logic          rd_phase,
   output logic          oe_gate,
   output logic [DW-1:0] rdata,
   output logic          rdata_valid
);
   localparam int HI_W = AW - BURST_W;

   generate
      if (AW <= BURST_W) begin : g_bad_aw
         $error("sram_burst_front: AW must exceed the burst counter width");
      end
      if (DW < 1) begin : g_bad_dw
         $error("sram_burst_front: DW must be at least 1");
      end
   endgenerate

   logic            load, proc_win, is_wr, adv_en;
   logic [HI_W-1:0] base_hi;
   burst_idx_t      low;
   logic [DW-1:0]   rdata_q;
   logic            was_sel, oe_mask;

   sbf_access_ctl u_ctl (
      .clk(clk), .rst_n(rst_n), .proc_as_n(proc_as_n), .ctrl_as_n(ctrl_as_n),
      .en1_n(en1_n), .en2(en2), .en3_n(en3_n), .we_n(we_n),
      .load(load), .proc_win(proc_win), .selected(selected), .is_wr(is_wr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    base_hi <= '0;
      else if (load) base_hi <= addr_in[AW-1:BURST_W];
   end

   assign adv_en = !load && !adv_n && selected;

   sbf_burst_ctr u_ctr (
      .clk(clk), .rst_n(rst_n), .load(load), .adv(adv_en),
      .order_sel(order_sel), .start_low(addr_in[BURST_W-1:0]), .low(low)
   );

   assign word_addr = {base_hi, low};
   assign rd_phase  = selected && !is_wr;

   sbf_mem #(.AW(AW), .DW(DW)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .wr_en(selected && is_wr), .rd_en(rd_phase),
      .addr(word_addr), .wdata(wdata),
      .rdata_q(rdata_q), .rd_valid(rdata_valid)
   );

   // first read word after a deselected access keeps the gate shut
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         was_sel <= 1'b0;
         oe_mask <= 1'b0;
      end else begin
         was_sel <= selected;
         oe_mask <= rd_phase && !was_sel;
      end
   end

   assign oe_gate = rdata_valid && !oe_n && !oe_mask;
   assign rdata   = oe_gate ? rdata_q : '0;

   AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !order_sel) |=> (word_addr == $past(addr_in))); // R1
   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && adv_n) |=> ($stable(word_addr) && $stable(selected))); // R7
   AST_RD_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_phase |=> rdata_valid); // R8
   AST_DESEL_NODATA: assert property (@(posedge clk) disable iff (!rst_n)
      !selected |=> !rdata_valid); // R9
   AST_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      oe_gate |-> (rdata_valid && !oe_n)); // R10
endmodule

// File: tb/sim_sram_burst_front.sv
module sim_sram_burst_front;
   localparam int AW = 6;
   localparam int DW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic proc_as_n = 1'b1, ctrl_as_n = 1'b1, en1_n = 1'b0, en2 = 1'b1, en3_n = 1'b0;
   logic adv_n = 1'b1, we_n = 1'b1, order_sel = 1'b0, oe_n = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic [DW-1:0] wdata = '0;
   logic [AW-1:0] word_addr;
   logic selected, rd_phase, oe_gate, rdata_valid;
   logic [DW-1:0] rdata;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sram_burst_front #(.AW(AW), .DW(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .proc_as_n(proc_as_n), .ctrl_as_n(ctrl_as_n),
      .en1_n(en1_n), .en2(en2), .en3_n(en3_n), .adv_n(adv_n), .we_n(we_n),
      .order_sel(order_sel), .oe_n(oe_n), .addr_in(addr_in), .wdata(wdata),
      .word_addr(word_addr), .selected(selected), .rd_phase(rd_phase),
      .oe_gate(oe_gate), .rdata(rdata), .rdata_valid(rdata_valid)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      chk("R7 reset selected", 32'(selected), 0);
      chk("R9 reset valid", 32'(rdata_valid), 0);
      chk("R1 reset addr", 32'(word_addr), 0);
   endtask

   task automatic t_write_linear();
      order_sel = 0; addr_in = 6'h10; ctrl_as_n = 0; we_n = 0;
      tick();
      chk("R1 load addr", 32'(word_addr), 32'h10);
      chk("R4 selected", 32'(selected), 1);
      chk("R2 ctrl write", 32'(rd_phase), 0);
      ctrl_as_n = 1; adv_n = 0; wdata = 16'h1111;
      tick(); chk("R5 linear +1", 32'(word_addr), 32'h11);
      wdata = 16'h2222;
      tick(); chk("R5 linear +2", 32'(word_addr), 32'h12);
      wdata = 16'h3333;
      tick(); chk("R5 linear +3", 32'(word_addr), 32'h13);
      wdata = 16'h4444; we_n = 1;
      tick(); chk("R5 linear wrap", 32'(word_addr), 32'h10);
      adv_n = 1; ctrl_as_n = 0; en2 = 0; addr_in = 6'h10;
      tick(); chk("R4 deselect", 32'(selected), 0);
      ctrl_as_n = 1; en2 = 1; we_n = 0; wdata = 16'hDEAD;
      tick(); chk("R9 no valid when deselected", 32'(rdata_valid), 0);
      tick(); chk("R9 still deselected", 32'(selected), 0);
      we_n = 1;
   endtask

   task automatic t_read_interleaved();
      order_sel = 1; proc_as_n = 0; addr_in = 6'h12;
      tick();
      chk("R1 proc load", 32'(word_addr), 32'h12);
      chk("R2 proc read", 32'(rd_phase), 1);
      proc_as_n = 1; adv_n = 0;
      tick();
      chk("R6 ilv step1", 32'(word_addr), 32'h13);
      chk("R8 valid", 32'(rdata_valid), 1);
      chk("R10 first word masked", 32'(oe_gate), 0);
      chk("R10 masked data zero", 32'(rdata), 0);
      tick();
      chk("R6 ilv step2", 32'(word_addr), 32'h10);
      chk("R8 data 0x13", 32'(rdata), 32'h4444);
      tick();
      chk("R6 ilv step3", 32'(word_addr), 32'h11);
      chk("R8 data 0x10", 32'(rdata), 32'h1111);
      tick();
      chk("R6 ilv repeat", 32'(word_addr), 32'h12);
      chk("R8 data 0x11", 32'(rdata), 32'h2222);
      adv_n = 1;
      tick();
      chk("R7 hold addr", 32'(word_addr), 32'h12);
      chk("R8 data 0x12", 32'(rdata), 32'h3333);
      oe_n = 1;
      tick();
      chk("R10 oe high valid", 32'(rdata_valid), 1);
      chk("R10 oe high data", 32'(rdata), 0);
      oe_n = 0;
   endtask

   task automatic t_read_linear();
      order_sel = 0; ctrl_as_n = 0; we_n = 1; addr_in = 6'h13;
      tick(); chk("R1 ctrl read load", 32'(word_addr), 32'h13);
      ctrl_as_n = 1; adv_n = 0;
      tick();
      chk("R5 linear wrap read", 32'(word_addr), 32'h10);
      chk("R10 no mask when selected", 32'(rdata), 32'h4444);
      tick();
      chk("R9 desel write suppressed", 32'(rdata), 32'h1111);
      adv_n = 1;
   endtask

   task automatic t_priority_and_enables();
      proc_as_n = 0; ctrl_as_n = 0; we_n = 0; addr_in = 6'h05; wdata = 16'h5555;
      tick();
      chk("R2 both strobes read", 32'(rd_phase), 1);
      chk("R2 both strobes addr", 32'(word_addr), 32'h05);
      proc_as_n = 1; addr_in = 6'h06;
      tick(); chk("R2 ctrl alone write", 32'(rd_phase), 0);
      ctrl_as_n = 1; we_n = 1; en1_n = 1; proc_as_n = 0; addr_in = 6'h2A;
      tick();
      chk("R3 proc masked addr", 32'(word_addr), 32'h06);
      chk("R3 proc masked sel", 32'(selected), 1);
      proc_as_n = 1; en1_n = 0; en2 = 0; en3_n = 1;
      tick(); chk("R4 enables ignored", 32'(selected), 1);
      en2 = 1; ctrl_as_n = 0; addr_in = 6'h20;
      tick();
      chk("R4 en3 deselects", 32'(selected), 0);
      chk("R1 deselect load addr", 32'(word_addr), 32'h20);
      ctrl_as_n = 1; en3_n = 0;
   endtask

   initial begin
      #1;
      t_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      tick();
      t_write_linear();
      t_read_interleaved();
      t_read_linear();
      t_priority_and_enables();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule